// File: doc/BRIEF.md
# Toggle-Serviced Watchdog Timer

This block supervises a host that talks to it over a serial command channel. Each command word arrives as one strobe, with a 4-bit address and 8 data bits. The watchdog is not serviced by a fixed key or by the arrival of a command. It is serviced when the top data bit (bit 7) of a command has a different value from the top bit of the command before it. A host that keeps talking must therefore keep flipping that bit.

The period is counted in millisecond ticks and is picked from four values by a 2-bit field in the watchdog configuration register. A newly written field does not shorten or lengthen a count that is already running. It is loaded only when a fresh count starts. A dedicated no-operation address lets traffic meant for other devices on a daisy chain pass through without altering any setting, while its bit 7 still services the watchdog. Once the count expires, a sticky timeout flag is raised for whatever fail-safe logic sits downstream.

Top module: `wdt_toggle_kick`

## Requirements
- R1: After reset, `timeout` is 0, the selected code is 00 and the previous-bit reference is 0.
- R2: The 2-bit period code is written through address 4'b1101 in data bits [1:0]. The codes map to periods of 00 = 620, 01 = 310, 10 = 2500 and 11 = 1250 ticks.
- R3: The count advances by one on each cycle with `tick_ms` high. `timeout` is 1 from the cycle after the tick that brings the count to the active period.
- R4: A command whose bit 7 differs from bit 7 of the previous command, at any address, restarts the count from zero.
- R5: A command whose bit 7 equals bit 7 of the previous command does not restart the count.
- R6: Writing a new code without a bit-7 change leaves the running period unchanged. The new code is loaded only at the next restart.
- R7: A write to address 4'b1101 that also changes bit 7 starts the new count with the code carried in that same write.
- R8: A command at the no-operation address 4'b0110 does not change the stored code, but a change in its bit 7 still restarts the count.
- R9: Commands at any address other than 4'b1101 leave the stored code unchanged.
- R10: `timeout` stays 1 until reset. Later bit-7 changes and ticks neither clear it nor restart the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command word |
| cmd_addr | input | 4 | Register address of the command |
| cmd_data | input | 8 | Command data; bit 7 is the service bit |
| tick_ms | input | 1 | Millisecond time base enable |
| timeout | output | 1 | Sticky watchdog expiry flag |

## Verification
The assertions check four things on every cycle: the flag is sticky, a service clears the count, a command with an unchanged bit 7 lets the count keep advancing, and a no-operation command leaves the stored code untouched. They also check that the count never passes the active period and holds when there is no tick. Only the bench's scenarios can show the exact expiry cycle for each of the four codes, and that a code written without a bit-7 change waits for the next restart. The same applies to a code written together with a bit-7 change taking effect at once, and to writes at foreign addresses leaving the code alone.

// File: rtl/wdt_pkg.sv
// Shared constants and types for the toggle-serviced watchdog.
package wdt_pkg;
    localparam logic [3:0] ADDR_WDOG = 4'b1101;
    localparam logic [3:0] ADDR_NOP  = 4'b0110;
    localparam int         KICK_BIT  = 7;

    typedef logic [1:0] wd_code_t;
    localparam wd_code_t CODE_RESET = 2'b00;
endpackage

// File: rtl/wdt_cmd_decode.sv
// Command decoder: keeps the stored period code and the bit-7 reference.
// Raises kick when bit 7 differs from the previous command's bit 7.
// Assumes cmd_valid is a single-cycle strobe per command word.
module wdt_cmd_decode
    import wdt_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [3:0]     cmd_addr,
    input  logic [7:0]     cmd_data,
    output logic           kick,
    output wd_code_t       code_next,
    output wd_code_t       code_stored,
    output logic           prev_bit
);
    logic code_wr;

    // Decode a configuration write and the service condition.
    always_comb begin
        code_wr   = cmd_valid && (cmd_addr == ADDR_WDOG);
        code_next = code_wr ? wd_code_t'(cmd_data[1:0]) : code_stored;
        kick      = cmd_valid && (cmd_data[KICK_BIT] != prev_bit);
    end

    // Store the code on a configuration write and the service bit on every command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_stored <= CODE_RESET;
            prev_bit    <= 1'b0;
        end else if (cmd_valid) begin
            code_stored <= code_next;
            prev_bit    <= cmd_data[KICK_BIT];
        end
    end
endmodule

// File: rtl/wdt_period_map.sv
// Maps a 2-bit code to a period in ticks. Pure combinational logic.
module wdt_period_map
    import wdt_pkg::*;
#(
    parameter int P00 = 620,
    parameter int P01 = 310,
    parameter int P10 = 2500,
    parameter int P11 = 1250,
    parameter int CW  = 12
) (
    input  wd_code_t       code,
    output logic [CW-1:0]  period
);
    // Select the period for the code.
    always_comb begin
        unique case (code)
            2'b00:   period = CW'(P00);
            2'b01:   period = CW'(P01);
            2'b10:   period = CW'(P10);
            default: period = CW'(P11);
        endcase
    end
endmodule

// File: rtl/wdt_counter.sv
// Tick counter with a code latched at each restart and a sticky expiry flag.
// Assumes period is never zero. After expiry the count freezes.
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           kick,
    input  logic           tick,
    input  wd_code_t       code_load,
    input  logic [CW-1:0]  period,
    output wd_code_t       code_active,
    output logic [CW-1:0]  count,
    output logic           expired
);
    logic [CW-1:0] count_inc;

    // Next count value.
    always_comb count_inc = count + CW'(1);

    // Restart, advance or expire the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count       <= '0;
            code_active <= CODE_RESET;
            expired     <= 1'b0;
        end else if (!expired) begin
            if (kick) begin
                count       <= '0;
                code_active <= code_load;
            end else if (tick) begin
                count <= count_inc;
                if (count_inc == period) expired <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/wdt_toggle_kick.sv
// Top of the toggle-serviced watchdog. Ties decoder, counter and period map.
// Assumes tick_ms is a one-cycle enable per millisecond.
module wdt_toggle_kick
    import wdt_pkg::*;
#(
    parameter int P00 = 620,
    parameter int P01 = 310,
    parameter int P10 = 2500,
    parameter int P11 = 1250,
    localparam int PMAX_A = (P00 > P01) ? P00 : P01,
    localparam int PMAX_B = (P10 > P11) ? P10 : P11,
    localparam int PMAX   = (PMAX_A > PMAX_B) ? PMAX_A : PMAX_B,
    localparam int CW     = $clog2(PMAX + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [3:0] cmd_addr,
    input  logic [7:0] cmd_data,
    input  logic       tick_ms,
    output logic       timeout
);
    logic          kick_w;
    logic          prev_bit_w;
    wd_code_t      code_next_w;
    wd_code_t      code_stored_w;
    wd_code_t      code_active_w;
    logic [CW-1:0] count_w;
    logic [CW-1:0] period_w;

    wdt_cmd_decode dec_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_addr   (cmd_addr),
        .cmd_data   (cmd_data),
        .kick       (kick_w),
        .code_next  (code_next_w),
        .code_stored(code_stored_w),
        .prev_bit   (prev_bit_w)
    );

    wdt_period_map #(.P00(P00), .P01(P01), .P10(P10), .P11(P11), .CW(CW)) map_i (
        .code  (code_active_w),
        .period(period_w)
    );

    wdt_counter #(.CW(CW)) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .kick       (kick_w),
        .tick       (tick_ms),
        .code_load  (code_next_w),
        .period     (period_w),
        .code_active(code_active_w),
        .count      (count_w),
        .expired    (timeout)
    );
endmodule

// File: rtl/wdt_toggle_kick_chk.sv
// Property checker for the toggle-serviced watchdog, attached by bind.
module wdt_toggle_kick_chk
    import wdt_pkg::*;
#(
    parameter int CW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [3:0]    cmd_addr,
    input logic [7:0]    cmd_data,
    input logic          tick_ms,
    input logic          timeout,
    input logic          kick,
    input logic          prev_bit,
    input logic [1:0]    code_stored,
    input logic [CW-1:0] count,
    input logic [CW-1:0] period
);
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> timeout);

    a_r4_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && !timeout) |=> (count == '0));

    a_r5_same_bit_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_data[KICK_BIT] == prev_bit) && tick_ms && !timeout)
            |=> (count == $past(count) + CW'(1)));

    a_r8_nop_keeps_code: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_addr == ADDR_NOP)) |=> $stable(code_stored));

    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= period);

    a_r3_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_ms && !kick) |=> $stable(count));
endmodule

bind wdt_toggle_kick wdt_toggle_kick_chk #(.CW(CW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_addr   (cmd_addr),
    .cmd_data   (cmd_data),
    .tick_ms    (tick_ms),
    .timeout    (timeout),
    .kick       (kick_w),
    .prev_bit   (prev_bit_w),
    .code_stored(code_stored_w),
    .count      (count_w),
    .period     (period_w)
);

// File: tb/wdt_toggle_kick_tb.sv
// Directed bench for the toggle-serviced watchdog.
module wdt_toggle_kick_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_addr = 4'h0;
    logic [7:0] cmd_data = 8'h00;
    logic       tick_ms = 1'b0;
    logic       timeout;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wdt_toggle_kick dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .tick_ms(tick_ms), .timeout(timeout)
    );

    // Watchdog for a hung run.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: timeout actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cmd_valid = 1'b0; tick_ms = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_ms = 1'b1;
        end
        @(negedge clk);
        tick_ms = 1'b0;
    endtask

    task automatic measure(input string req, input int period);
        ticks(period - 1);
        chk(req, timeout, 1'b0);
        ticks(1);
        chk(req, timeout, 1'b1);
    endtask

    // R1, R2, R3: reset state and default period.
    task automatic t_reset();
        do_reset();
        chk("R1", timeout, 1'b0);
        measure("R3 default code 00", 620);
    endtask

    // R2, R7: every code applied by a write that also flips bit 7.
    task automatic t_codes();
        int exp_p [4] = '{620, 310, 2500, 1250};
        for (int c = 0; c < 4; c++) begin
            do_reset();
            send(4'b1101, {1'b1, 5'b0, 2'(c)});
            measure("R2 R7 code period", exp_p[c]);
        end
    endtask

    // R6, R8: code written without a flip waits for the next restart.
    task automatic t_deferred();
        do_reset();
        send(4'b1101, 8'h01);
        ticks(400);
        chk("R6 old period still running", timeout, 1'b0);
        send(4'b0110, 8'h80);
        measure("R6 R8 new period after nop service", 310);
    endtask

    // R5: same bit 7 does not restart.
    task automatic t_same_bit();
        do_reset();
        ticks(300);
        send(4'b0110, 8'h00);
        ticks(319);
        chk("R5 no restart", timeout, 1'b0);
        ticks(1);
        chk("R5 expiry at original period", timeout, 1'b1);
    endtask

    // R4: flips at two addresses restart the count.
    task automatic t_kick();
        do_reset();
        ticks(600);
        send(4'b0110, 8'h80);
        ticks(600);
        chk("R4 restart by nop flip", timeout, 1'b0);
        send(4'b1101, 8'h00);
        measure("R4 restart by config flip", 620);
    endtask

    // R8, R9: foreign and nop addresses do not touch the code.
    task automatic t_foreign();
        do_reset();
        send(4'b0110, 8'h81);
        measure("R8 nop keeps code", 620);
        do_reset();
        send(4'b0100, 8'h82);
        measure("R9 foreign keeps code", 620);
    endtask

    // R10: flag stays set after flips and ticks.
    task automatic t_sticky();
        do_reset();
        send(4'b1101, 8'h81);
        ticks(310);
        chk("R10 expired", timeout, 1'b1);
        send(4'b0110, 8'h00);
        send(4'b1101, 8'h80);
        ticks(50);
        chk("R10 still set", timeout, 1'b1);
    endtask

    initial begin
        t_reset();
        t_codes();
        t_deferred();
        t_same_bit();
        t_kick();
        t_foreign();
        t_sticky();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule